// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

This block copies data from one memory location to another without processor help. All channel state is kept in 8-byte descriptors in shared RAM. A one-cycle `start` pulse carries a descriptor address. The engine then works through four phases in order:

1. It reads the descriptor over a byte-wide memory bus.
2. It moves one block by alternating reads and writes.
3. It computes the new descriptor contents.
4. It writes the whole descriptor back.

The engine holds no channel registers between activations.

Each descriptor selects its own mode:

- **Normal mode** counts blocks down to zero.
- **Repeat mode** restores one address and reloads the count whenever the count expires.
- **Chaining** runs the next descriptor, 8 bytes higher, inside the same activation.

When the engine finishes, it gives a one-cycle `done` strobe. Alongside it come an interrupt request and a request to clear the activation enable of the source that started it. Only the first descriptor of a chain decides these two flags.

Top module: `xfer_engine`

## Requirements

- R1: On an accepted `start`, the engine first reads descriptor bytes at `start_addr`+0 through +7, one at a time and in ascending order. Byte 0 is the control byte, byte 1 the block size, byte 2 the count and byte 3 the reload value. Bytes 4–5 hold the source address and bytes 6–7 the destination address, low byte first.
- R2: Control byte encoding:
  - bit0: 16-bit units
  - bit1: repeat interrupt enable
  - bit2: chain
  - bit3: destination increments
  - bit4: source increments
  - bit5: the repeat area is the destination (0 means the source)
  - bit6: repeat mode
  - bit7: must be 0
- R3: A block holds N units, where N is the block-size byte (0 means 256). A unit is 1 byte, or 2 bytes when bit0 is set. Each byte is read from the source and then written to the destination before the next byte is moved. The two bytes of a 16-bit unit use consecutive addresses, low byte first.
- R4: An incrementing address steps one byte address per byte moved within the block. A fixed address reuses the same address (or pair of addresses, for 16-bit units) for every unit. After the block, an incrementing address advances by the block's byte count in the written-back descriptor, and a fixed address is unchanged.
- R5: After the block, the engine writes all 8 descriptor bytes back to their own addresses in ascending order. In normal mode the count is decremented; a count of 0 stands for 256, so it becomes FFh. A normal-mode transfer that takes the count from 01h to 00h raises both `irq_req` and `en_clr`.
- R6: In repeat mode, the repeat-area address always increments, whatever its increment bit says. When the count is 01h, the written-back count is the reload byte and the repeat-area address becomes its high byte followed by 00h.
- R7: In repeat mode, expiry of the count raises `irq_req` and `en_clr` only when bit1 is set. Otherwise no flag is raised.
- R8: When a completed descriptor has bit2 set, the engine fetches the descriptor 8 bytes higher and processes it within the same activation. This continues until a descriptor with bit2 clear has been written back.
- R9: Only the first descriptor of an activation decides `irq_req` and `en_clr`. Both flags appear together with `done` at the end of the whole chain.
- R10: `busy` rises the cycle after an accepted `start` and stays high until the last write-back has been issued. `done` pulses for one cycle as `busy` falls. A `start` arriving while `busy` is high is ignored. No memory access happens while idle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Activation pulse, accepted only while idle |
| start_addr | input | 16 | Address of the first descriptor |
| busy | output | 1 | Activation in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the read request |
| done | output | 1 | One-cycle end-of-activation strobe |
| irq_req | output | 1 | Interrupt request, valid with `done` |
| en_clr | output | 1 | Clear-activation-enable request, valid with `done` |

## Verification

The assertions assume a memory that always accepts an access and returns read data exactly one cycle after the request. They also assume that the descriptors, source regions and destination regions of one activation never overlap, so that no written byte is read again in the same activation. The stimulus respects both assumptions. It places every descriptor, source buffer and destination buffer in a separate region of the bench's byte array. It starts repeat areas on an address with low byte 00h and keeps bit7 of the control byte clear. The bench also pulses `start` again during busy activations so that the ignore rule is exercised.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int ADDR_W   = 16;
    localparam int DESC_LEN = 8;
    localparam int IDX_W    = $clog2(DESC_LEN);
    localparam int BCNT_W   = 10;            // up to 512 bytes per block

    // byte offsets inside a descriptor
    localparam int OFS_CTRL = 0;
    localparam int OFS_BLK  = 1;
    localparam int OFS_CNT  = 2;
    localparam int OFS_RLD  = 3;
    localparam int OFS_SRC  = 4;
    localparam int OFS_DST  = 6;

    typedef logic [DESC_LEN-1:0][7:0] desc_t;

    typedef struct packed {
        logic spare;
        logic rpt_mode;
        logic rpt_dst;
        logic src_inc;
        logic dst_inc;
        logic chain;
        logic rpt_ie;
        logic sz16;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DRD  = 3'd1,
        S_DCAP = 3'd2,
        S_XRD  = 3'd3,
        S_XCAP = 3'd4,
        S_XWR  = 3'd5,
        S_WB   = 3'd6
    } state_e;

    typedef struct packed {
        state_e              state;
        logic [IDX_W-1:0]    idx;
        desc_t               desc;
        logic [ADDR_W-1:0]   base;
        logic [BCNT_W-1:0]   bidx;
        logic [7:0]          data;
        logic                first;
        logic                irq_pend;
        logic                clr_pend;
        logic                done;
        logic                irq;
        logic                clr;
    } regs_t;

endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
    parameter int AW = 16,
    parameter int BW = 10
) (
    input  logic [AW-1:0] base_i,
    input  logic          incr_i,
    input  logic          sz16_i,
    input  logic [BW-1:0] bidx_i,
    output logic [AW-1:0] addr_o
);
    localparam int PAD = AW - BW;

    logic [AW-1:0] ofs;

    always_comb begin
        if (incr_i) begin
            ofs = {{PAD{1'b0}}, bidx_i};
        end else begin
            // fixed: only the byte lane of a 16-bit unit moves
            ofs = {{(AW-1){1'b0}}, bidx_i[0] & sz16_i};
        end
    end

    assign addr_o = base_i + ofs;

endmodule

// File: rtl/xfer_desc_calc.sv
module xfer_desc_calc
    import xfer_pkg::*;
(
    input  desc_t             desc_i,
    output desc_t             desc_o,
    output logic [BCNT_W-1:0] last_idx_o,
    output logic              src_inc_o,
    output logic              dst_inc_o,
    output logic              sz16_o,
    output logic              chain_o,
    output logic              irq_o,
    output logic              clr_o
);
    localparam int PAD = ADDR_W - BCNT_W;

    ctrl_t             ctl;
    logic [8:0]        units;
    logic [BCNT_W-1:0] nbytes;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] src_cur, dst_cur, src_nxt, dst_nxt;
    logic [7:0]        cnt_nxt;
    logic              expire;

    always_comb begin
        ctl     = ctrl_t'(desc_i[OFS_CTRL]);
        units   = {desc_i[OFS_BLK] == 8'h00, desc_i[OFS_BLK]};
        nbytes  = ctl.sz16 ? {units, 1'b0} : {1'b0, units};
        step    = {{PAD{1'b0}}, nbytes};
        src_cur = {desc_i[OFS_SRC+1], desc_i[OFS_SRC]};
        dst_cur = {desc_i[OFS_DST+1], desc_i[OFS_DST]};
        expire  = (desc_i[OFS_CNT] == 8'h01);

        // repeat area is forced to increment
        src_inc_o = ctl.rpt_mode ? (~ctl.rpt_dst | ctl.src_inc) : ctl.src_inc;
        dst_inc_o = ctl.rpt_mode ? ( ctl.rpt_dst | ctl.dst_inc) : ctl.dst_inc;

        src_nxt = src_inc_o ? src_cur + step : src_cur;
        dst_nxt = dst_inc_o ? dst_cur + step : dst_cur;
        cnt_nxt = desc_i[OFS_CNT] - 8'h01;

        if (ctl.rpt_mode && expire) begin
            cnt_nxt = desc_i[OFS_RLD];
            if (ctl.rpt_dst) dst_nxt = {dst_cur[ADDR_W-1:8], 8'h00};
            else             src_nxt = {src_cur[ADDR_W-1:8], 8'h00};
        end

        desc_o               = desc_i;
        desc_o[OFS_CNT]      = cnt_nxt;
        desc_o[OFS_SRC]      = src_nxt[7:0];
        desc_o[OFS_SRC+1]    = src_nxt[15:8];
        desc_o[OFS_DST]      = dst_nxt[7:0];
        desc_o[OFS_DST+1]    = dst_nxt[15:8];

        last_idx_o = nbytes - BCNT_W'(1);
        sz16_o     = ctl.sz16;
        chain_o    = ctl.chain;
        irq_o      = expire & (~ctl.rpt_mode | ctl.rpt_ie);
        clr_o      = irq_o;
    end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              irq_req,
    output logic              en_clr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_LEN - 1);
    localparam int               NPTR     = 2;   // 0 = source, 1 = destination

    regs_t r_q, r_d;

    desc_t                       upd;
    logic [BCNT_W-1:0]           last_idx;
    logic                        src_inc, dst_inc, sz16, chain, irq_c, clr_c;
    logic [NPTR-1:0][ADDR_W-1:0] ptr_base, ptr_addr;
    logic [NPTR-1:0]             ptr_inc;

    xfer_desc_calc u_calc (
        .desc_i     (r_q.desc),
        .desc_o     (upd),
        .last_idx_o (last_idx),
        .src_inc_o  (src_inc),
        .dst_inc_o  (dst_inc),
        .sz16_o     (sz16),
        .chain_o    (chain),
        .irq_o      (irq_c),
        .clr_o      (clr_c)
    );

    assign ptr_base[0] = {r_q.desc[OFS_SRC+1], r_q.desc[OFS_SRC]};
    assign ptr_base[1] = {r_q.desc[OFS_DST+1], r_q.desc[OFS_DST]};
    assign ptr_inc     = {dst_inc, src_inc};

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        xfer_addr_gen #(.AW(ADDR_W), .BW(BCNT_W)) u_ag (
            .base_i (ptr_base[g]),
            .incr_i (ptr_inc[g]),
            .sz16_i (sz16),
            .bidx_i (r_q.bidx),
            .addr_o (ptr_addr[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.irq   = 1'b0;
        r_d.clr   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.base + {{(ADDR_W-IDX_W){1'b0}}, r_q.idx};
        mem_wdata = 8'h00;

        case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.state    = S_DRD;
                    r_d.base     = start_addr;
                    r_d.idx      = '0;
                    r_d.first    = 1'b1;
                    r_d.irq_pend = 1'b0;
                    r_d.clr_pend = 1'b0;
                end
            end
            S_DRD: begin
                mem_req   = 1'b1;
                r_d.state = S_DCAP;
            end
            S_DCAP: begin
                r_d.desc[r_q.idx] = mem_rdata;
                if (r_q.idx == LAST_IDX) begin
                    r_d.bidx  = '0;
                    r_d.state = S_XRD;
                end else begin
                    r_d.idx   = r_q.idx + 1'b1;
                    r_d.state = S_DRD;
                end
            end
            S_XRD: begin
                mem_req   = 1'b1;
                mem_addr  = ptr_addr[0];
                r_d.state = S_XCAP;
            end
            S_XCAP: begin
                r_d.data  = mem_rdata;
                r_d.state = S_XWR;
            end
            S_XWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_addr[1];
                mem_wdata = r_q.data;
                if (r_q.bidx == last_idx) begin
                    r_d.idx   = '0;
                    r_d.state = S_WB;
                end else begin
                    r_d.bidx  = r_q.bidx + 1'b1;
                    r_d.state = S_XRD;
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = upd[r_q.idx];
                if (r_q.idx == LAST_IDX) begin
                    r_d.first = 1'b0;
                    if (r_q.first) begin
                        r_d.irq_pend = irq_c;
                        r_d.clr_pend = clr_c;
                    end
                    if (chain) begin
                        r_d.base  = r_q.base + ADDR_W'(DESC_LEN);
                        r_d.idx   = '0;
                        r_d.state = S_DRD;
                    end else begin
                        r_d.state = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.irq   = r_q.first ? irq_c : r_q.irq_pend;
                        r_d.clr   = r_q.first ? clr_c : r_q.clr_pend;
                    end
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.state != S_IDLE);
    assign done    = r_q.done;
    assign irq_req = r_q.irq;
    assign en_clr  = r_q.clr;

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        done,
    input logic        irq_req,
    input logic        en_clr
);
    // R10
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    // R9
    flags_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || en_clr) |-> done);

    // R7
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == en_clr);

    // R2
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

endmodule

bind xfer_engine xfer_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .done    (done),
    .irq_req (irq_req),
    .en_clr  (en_clr)
);

// File: tb/tb_xfer_engine.sv
module tb_xfer_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    localparam logic [7:0] C_SZ = 8'h01, C_RIE = 8'h02, C_CHN = 8'h04, C_DINC = 8'h08,
                           C_SINC = 8'h10, C_RDST = 8'h20, C_RPT = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = 16'h0;
    logic        busy, mem_req, mem_we, done, irq_req, en_clr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  rdata_q = 8'h00;

    logic [7:0]  mem [0:4095];

    bit          q_we   [$];
    logic [15:0] q_addr [$];
    logic [7:0]  q_data [$];
    string       q_tag  [$];

    int n_chk = 0;
    int n_bad = 0;
    bit exp_irq;

    xfer_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (rdata_q),
        .done       (done),
        .irq_req    (irq_req),
        .en_clr     (en_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        rdata_q <= mem[mem_addr[11:0]];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit we, input logic [15:0] a, input logic [7:0] d, input string t);
        q_we.push_back(we);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(t);
    endtask

    // monitor: compares every bus access against the expected stream
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (q_we.size() == 0) begin
                check(1'b0, "R10", "unexpected bus access", {mem_we, mem_addr}, 0);
            end else begin
                bit          ew;
                logic [15:0] ea;
                logic [7:0]  ed;
                string       et;
                ew = q_we.pop_front();
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                check(mem_we == ew && mem_addr == ea && (!ew || mem_wdata == ed), et,
                      "bus access {we,addr,data}", {mem_we, mem_addr, mem_wdata}, {ew, ea, ed});
            end
        end
    end

    task automatic set_desc(input logic [15:0] a, input logic [7:0] c, input logic [7:0] blk,
                            input logic [7:0] cnt, input logic [7:0] rld,
                            input logic [15:0] s, input logic [15:0] d);
        mem[a[11:0]]      = c;
        mem[a[11:0] + 1]  = blk;
        mem[a[11:0] + 2]  = cnt;
        mem[a[11:0] + 3]  = rld;
        mem[a[11:0] + 4]  = s[7:0];
        mem[a[11:0] + 5]  = s[15:8];
        mem[a[11:0] + 6]  = d[7:0];
        mem[a[11:0] + 7]  = d[15:8];
    endtask

    // reference model built from the requirements
    task automatic model(input logic [15:0] a0);
        logic [15:0] a, s, d, ns, nd, sa, da;
        logic [7:0]  c, blk, cnt, rld, ncnt;
        bit          first, more, sz, rie, chn, rdst, rpt, se, de, fin;
        int          nb;
        a = a0; first = 1'b1; more = 1'b1;
        while (more) begin
            c   = mem[a[11:0]];
            blk = mem[a[11:0] + 1];
            cnt = mem[a[11:0] + 2];
            rld = mem[a[11:0] + 3];
            s   = {mem[a[11:0] + 5], mem[a[11:0] + 4]};
            d   = {mem[a[11:0] + 7], mem[a[11:0] + 6]};
            sz = c[0]; rie = c[1]; chn = c[2]; rdst = c[5]; rpt = c[6];
            se = rpt ? (!rdst || c[4]) : c[4];
            de = rpt ? ( rdst || c[3]) : c[3];
            fin = (cnt == 8'h01);
            nb = ((blk == 8'h00) ? 256 : int'(blk)) * (sz ? 2 : 1);
            for (int i = 0; i < 8; i++) push(1'b0, 16'(a + i), 8'h00, first ? "R1" : "R8");
            for (int b = 0; b < nb; b++) begin
                sa = se ? 16'(s + b) : 16'(s + (b & int'(sz)));
                da = de ? 16'(d + b) : 16'(d + (b & int'(sz)));
                push(1'b0, sa, 8'h00, "R4");
                push(1'b1, da, mem[sa[11:0]], "R3");
            end
            ns   = se ? 16'(s + nb) : s;
            nd   = de ? 16'(d + nb) : d;
            ncnt = cnt - 8'h01;
            if (rpt && fin) begin
                ncnt = rld;
                if (rdst) nd = {d[15:8], 8'h00};
                else      ns = {s[15:8], 8'h00};
            end
            push(1'b1, a,            c,         rpt ? "R6" : "R5");
            push(1'b1, 16'(a + 1),   blk,       rpt ? "R6" : "R5");
            push(1'b1, 16'(a + 2),   ncnt,      rpt ? "R6" : "R5");
            push(1'b1, 16'(a + 3),   rld,       rpt ? "R6" : "R5");
            push(1'b1, 16'(a + 4),   ns[7:0],   rpt ? "R6" : "R4");
            push(1'b1, 16'(a + 5),   ns[15:8],  rpt ? "R6" : "R4");
            push(1'b1, 16'(a + 6),   nd[7:0],   rpt ? "R6" : "R4");
            push(1'b1, 16'(a + 7),   nd[15:8],  rpt ? "R6" : "R4");
            if (first) exp_irq = fin && (!rpt || rie);
            first = 1'b0;
            if (chn) a = 16'(a + 8);
            else     more = 1'b0;
        end
    endtask

    task automatic activate(input logic [15:0] a, input bit poke, input string ftag);
        int guard;
        model(a);
        @(negedge clk);
        start = 1'b1;
        start_addr = a;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", "busy after start", busy, 1);
        if (poke) begin
            start = 1'b1;
            start_addr = 16'(a + 16);
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1 && busy == 1'b0, "R10", "done with busy low", {done, busy}, 2);
        check(irq_req == exp_irq, ftag, "irq_req at done", irq_req, exp_irq);
        check(en_clr == exp_irq, ftag, "en_clr at done", en_clr, exp_irq);
        check(q_we.size() == 0, "R2", "pending expected accesses", q_we.size(), 0);
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R10", "idle after done", {done, busy}, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0 && irq_req == 1'b0,
              "R10", "reset state", {busy, done, mem_req, irq_req}, 0);

        // normal, source fixed, destination increments, count 3 (R5)
        set_desc(16'h0100, C_DINC, 8'd1, 8'd3, 8'd0, 16'h0200, 16'h0300);
        activate(16'h0100, 1'b0, "R5");
        activate(16'h0100, 1'b1, "R5");
        activate(16'h0100, 1'b0, "R5");

        // normal, 16-bit units, both increment, count 1 (R3, R5)
        set_desc(16'h0108, C_SZ | C_SINC | C_DINC, 8'd2, 8'd1, 8'd0, 16'h0210, 16'h0320);
        activate(16'h0108, 1'b0, "R5");

        // normal, 16-bit units, source fixed (R4)
        set_desc(16'h0128, C_SZ | C_DINC, 8'd3, 8'd9, 8'd0, 16'h0250, 16'h0380);
        activate(16'h0128, 1'b0, "R4");

        // block size 00h = 256 bytes, count 00h = 256 (R3, R5)
        set_desc(16'h0110, C_SINC | C_DINC, 8'h00, 8'h00, 8'd0, 16'h0400, 16'h0600);
        activate(16'h0110, 1'b0, "R5");

        // repeat, destination area, no repeat interrupt (R6, R7)
        set_desc(16'h0118, C_RPT | C_RDST, 8'd1, 8'd2, 8'd2, 16'h0220, 16'h0A00);
        activate(16'h0118, 1'b0, "R7");
        activate(16'h0118, 1'b1, "R7");
        activate(16'h0118, 1'b0, "R7");

        // repeat, source area, 16-bit, repeat interrupt enabled (R6, R7)
        set_desc(16'h0120, C_RPT | C_RIE | C_SZ, 8'd1, 8'd1, 8'd4, 16'h0B00, 16'h0330);
        activate(16'h0120, 1'b0, "R7");

        // chain whose first descriptor expires (R8, R9)
        set_desc(16'h0140, C_CHN | C_DINC, 8'd1, 8'd1, 8'd0, 16'h0230, 16'h0340);
        set_desc(16'h0148, C_SINC | C_DINC, 8'd3, 8'd5, 8'd0, 16'h0240, 16'h0350);
        activate(16'h0140, 1'b1, "R9");

        // chain whose last descriptor expires: no flags (R9)
        set_desc(16'h0160, C_CHN | C_DINC, 8'd1, 8'd4, 8'd0, 16'h0260, 16'h0360);
        set_desc(16'h0168, C_CHN | C_SINC, 8'd2, 8'd7, 8'd0, 16'h0270, 16'h0370);
        set_desc(16'h0170, C_DINC, 8'd1, 8'd1, 8'd0, 16'h0280, 16'h0390);
        activate(16'h0160, 1'b0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule